// File: doc/BRIEF.md
# Pin-Level Test Vector Sequencer and Checker

This block runs a stored list of pin-level test vectors against a 20-pin logic device and reports whether the device answered as expected. Each vector holds one 3-bit symbol per pin. A symbol tells the block to drive the pin low or high, or to toggle it as a don't-care input. It can also expect the pin high or low, expect it to float, pulse it as a clock, or leave it alone. The block drives the device, pulses any clock pins, samples the pins and compares them with the symbols.

Software loads vectors through a write port while the block is idle, then starts a run with a vector count. Vectors are applied in index order. A vector that holds any don't-care pin is applied twice: once with every don't-care pin low, then once with all of them high. The block never works through all their combinations. A float expectation is tested by pulling the pin weakly high and then weakly low, and the pin must follow both times. The run stops at the first failing vector and reports its index and a mask of the pins that failed. If no vector fails, the run ends with an all-pass verdict. Running one vector set against an original part and against its replacement shows whether the two behave alike.

Top module: `pin_vector_checker`

## Requirements
- R1: Pin k's symbol sits at vector bits [3k+2:3k]. The codes are 0 not tested, 1 drive low, 2 drive high, 3 don't-care input, 4 expect high, 5 expect low, 6 expect floating, 7 clock. A write stores a vector only while `busy` is 0, and writes made while `busy` is 1 are ignored.
- R2: After reset, `busy`, `done`, `fail` and `all_pass` are 0, and every drive enable and pull enable is 0.
- R3: Drive-low and drive-high pins are driven at their level for the whole application of a pass. Not-tested pins are never driven, never pulled and never reported.
- R4: A vector with at least one don't-care pin is applied in two passes, with all don't-care pins low in the first and high in the second. A vector without one gets a single pass.
- R5: Clock pins are driven low and then high for exactly one cycle, then low again, before any output is sampled.
- R6: An expect-high pin fails if its sampled level is 0, and an expect-low pin fails if its sampled level is 1.
- R7: An expect-floating pin is pulled high for one cycle and then pulled low for one cycle, and it is never driven. It fails unless it reads 1 under the high pull and 0 under the low pull.
- R8: The run stops after the first pass that has any failing pin. It then sets `fail`, gives the vector's index in `fail_index` and sets bit k of `fail_mask` for each failing pin k. These are held until the next accepted start.
- R9: A run in which every vector passes ends with `all_pass` at 1 and `fail` at 0. A run length of 0 ends at once with `all_pass` at 1.
- R10: `done` is high for exactly one cycle at the end of a run, in the same cycle in which `busy` falls. While idle, all drive and pull enables are 0. A start while `busy` is 1 is ignored.
- R11: Each vector takes one fetch cycle plus six cycles per pass: apply, clock high, clock low, pull high, pull low, evaluate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store a vector (honoured only when idle) |
| wr_addr | input | 8 | Vector index to write |
| wr_data | input | 60 | Vector, 3 bits per pin |
| start | input | 1 | Begin a run (honoured only when idle) |
| run_len | input | 9 | Number of vectors to run, 0 to 256 |
| pin_in | input | 20 | Sampled level of each device pin |
| pin_drive_en | output | 20 | Strong drive enable per pin |
| pin_drive_val | output | 20 | Strong drive level per pin |
| pin_pull_en | output | 20 | Weak pull enable per pin |
| pin_pull_val | output | 20 | Weak pull direction per pin (1 = up) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Run stopped on a failing vector |
| all_pass | output | 1 | Run finished with every vector passing |
| fail_index | output | 8 | Index of the failing vector |
| fail_mask | output | 20 | Pins that failed in that vector |

## Verification
A phase counter that slips by one state shows up in the pin enables at once. The clock pulse lands in the wrong cycle, or the pulls open while strong drives are still on, so a per-cycle comparison of the pin outputs reports it in the same cycle. A wrong pass flag or a lost don't-care state changes the drive levels in the second pass, or the number of cycles before `done`, within seven cycles. A fault in the error accumulator or the stop decision only shows when the run ends, as a wrong verdict, index or mask, so the bench ends runs on a failing first pass, a failing second pass, a floating-pin failure and a failure on several pins at once.

// File: rtl/pvc_pkg.sv
package pvc_pkg;

   localparam int SYM_W = 3;

   // Per-pin symbol codes (R1)
   typedef enum logic [SYM_W-1:0] {
      SYM_SKIP   = 3'd0,
      SYM_LOW    = 3'd1,
      SYM_HIGH   = 3'd2,
      SYM_EITHER = 3'd3,
      SYM_EXP_H  = 3'd4,
      SYM_EXP_L  = 3'd5,
      SYM_EXP_Z  = 3'd6,
      SYM_CLOCK  = 3'd7
   } sym_e;

   // Sequencer phases, one cycle each (R11)
   typedef enum logic [2:0] {
      PH_IDLE    = 3'd0,
      PH_FETCH   = 3'd1,
      PH_APPLY   = 3'd2,
      PH_CLK_HI  = 3'd3,
      PH_CLK_LO  = 3'd4,
      PH_PULL_HI = 3'd5,
      PH_PULL_LO = 3'd6,
      PH_EVAL    = 3'd7
   } phase_e;

endpackage

// File: rtl/pvc_vec_store.sv
module pvc_vec_store #(
   parameter int W        = 60,
   parameter int DEPTH    = 256,
   parameter int AW       = 8,
   parameter bit REG_READ = 1'b1
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [W-1:0]  wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [W-1:0]  rd_data
);

   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   generate
      if (REG_READ) begin : g_flop_read
         logic [W-1:0] rd_q;
         always_ff @(posedge clk) rd_q <= mem[rd_addr];
         assign rd_data = rd_q;
      end else begin : g_comb_read
         assign rd_data = mem[rd_addr];
      end
   endgenerate

endmodule

// File: rtl/pvc_pin_cell.sv
module pvc_pin_cell
   import pvc_pkg::*;
(
   input  sym_e   sym,
   input  phase_e phase,
   input  logic   xval,
   input  logic   level,
   output logic   drive_en,
   output logic   drive_val,
   output logic   pull_en,
   output logic   pull_val,
   output logic   err,
   output logic   is_x
);

   logic active, is_drv, err_up, err_dn;

   assign active = (phase inside {PH_APPLY, PH_CLK_HI, PH_CLK_LO,
                                  PH_PULL_HI, PH_PULL_LO, PH_EVAL});
   assign is_drv = (sym inside {SYM_LOW, SYM_HIGH, SYM_EITHER, SYM_CLOCK});
   assign is_x   = (sym == SYM_EITHER);

   // Strong drive: fixed levels, shared don't-care level, clock pulse (R3 R4 R5)
   assign drive_en  = active && is_drv;
   assign drive_val = drive_en &&
                      ((sym == SYM_HIGH) ||
                       (is_x && xval) ||
                       ((sym == SYM_CLOCK) && (phase == PH_CLK_HI)));

   // Weak pull for floating checks (R7)
   assign pull_en  = (sym == SYM_EXP_Z) &&
                     ((phase == PH_PULL_HI) || (phase == PH_PULL_LO));
   assign pull_val = pull_en && (phase == PH_PULL_HI);

   // Comparison (R6 R7)
   assign err_up = (phase == PH_PULL_HI) &&
                   (((sym == SYM_EXP_H) && !level) ||
                    ((sym == SYM_EXP_L) &&  level) ||
                    ((sym == SYM_EXP_Z) && !level));
   assign err_dn = (phase == PH_PULL_LO) && (sym == SYM_EXP_Z) && level;
   assign err    = err_up || err_dn;

endmodule

// File: rtl/pvc_seq.sv
module pvc_seq
   import pvc_pkg::*;
#(
   parameter int PINS  = 20,
   parameter int DEPTH = 256,
   parameter int IDX_W = 8,
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] run_len,
   input  logic             has_x,
   input  logic [PINS-1:0]  pin_err,
   output phase_e           phase,
   output logic             xval,
   output logic [IDX_W-1:0] idx,
   output logic             busy,
   output logic             done,
   output logic             fail,
   output logic             all_pass,
   output logic [IDX_W-1:0] fail_index,
   output logic [PINS-1:0]  fail_mask
);

   localparam logic [CNT_W-1:0] MAX_LEN = CNT_W'(DEPTH);

   phase_e           state;
   logic [CNT_W-1:0] len_q;
   logic [PINS-1:0]  acc;
   logic             last_vec;

   assign phase    = state;
   assign busy     = (state != PH_IDLE);
   assign last_vec = ((CNT_W'(idx) + CNT_W'(1)) == len_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= PH_IDLE;
         len_q      <= '0;
         idx        <= '0;
         xval       <= 1'b0;
         acc        <= '0;
         done       <= 1'b0;
         fail       <= 1'b0;
         all_pass   <= 1'b0;
         fail_index <= '0;
         fail_mask  <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            PH_IDLE: if (start) begin
               fail       <= 1'b0;
               all_pass   <= 1'b0;
               fail_index <= '0;
               fail_mask  <= '0;
               idx        <= '0;
               xval       <= 1'b0;
               if (run_len == '0) begin
                  done     <= 1'b1;
                  all_pass <= 1'b1;
               end else begin
                  len_q <= (run_len > MAX_LEN) ? MAX_LEN : run_len;
                  state <= PH_FETCH;
               end
            end
            PH_FETCH: begin
               acc   <= '0;
               xval  <= 1'b0;
               state <= PH_APPLY;
            end
            PH_APPLY:  state <= PH_CLK_HI;
            PH_CLK_HI: state <= PH_CLK_LO;
            PH_CLK_LO: state <= PH_PULL_HI;
            PH_PULL_HI: begin
               acc   <= acc | pin_err;
               state <= PH_PULL_LO;
            end
            PH_PULL_LO: begin
               acc   <= acc | pin_err;
               state <= PH_EVAL;
            end
            PH_EVAL: begin
               if (acc != '0) begin
                  fail       <= 1'b1;
                  fail_index <= idx;
                  fail_mask  <= acc;
                  done       <= 1'b1;
                  state      <= PH_IDLE;
               end else if (has_x && !xval) begin
                  xval  <= 1'b1;
                  acc   <= '0;
                  state <= PH_APPLY;
               end else if (last_vec) begin
                  all_pass <= 1'b1;
                  done     <= 1'b1;
                  state    <= PH_IDLE;
               end else begin
                  idx   <= idx + IDX_W'(1);
                  state <= PH_FETCH;
               end
            end
            default: state <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/pin_vector_checker.sv
module pin_vector_checker
   import pvc_pkg::*;
#(
   parameter int PINS     = 20,
   parameter int DEPTH    = 256,
   parameter bit REG_READ = 1'b1,
   localparam int VEC_W   = PINS * SYM_W,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [VEC_W-1:0] wr_data,
   input  logic             start,
   input  logic [CNT_W-1:0] run_len,
   input  logic [PINS-1:0]  pin_in,
   output logic [PINS-1:0]  pin_drive_en,
   output logic [PINS-1:0]  pin_drive_val,
   output logic [PINS-1:0]  pin_pull_en,
   output logic [PINS-1:0]  pin_pull_val,
   output logic             busy,
   output logic             done,
   output logic             fail,
   output logic             all_pass,
   output logic [IDX_W-1:0] fail_index,
   output logic [PINS-1:0]  fail_mask
);

   generate
      if (PINS < 1 || PINS > 64) begin : g_bad_pins
         $error("pin_vector_checker: PINS must lie in 1..64");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("pin_vector_checker: DEPTH must be at least 2");
      end
   endgenerate

   logic [VEC_W-1:0] vec;
   logic [IDX_W-1:0] idx;
   logic [PINS-1:0]  pin_err, pin_x;
   phase_e           phase;
   logic             xval;

   pvc_vec_store #(
      .W(VEC_W), .DEPTH(DEPTH), .AW(IDX_W), .REG_READ(REG_READ)
   ) u_store (
      .clk     (clk),
      .wr_en   (wr_en && !busy),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (idx),
      .rd_data (vec)
   );

   generate
      for (genvar k = 0; k < PINS; k++) begin : g_pin
         pvc_pin_cell u_cell (
            .sym       (sym_e'(vec[k*SYM_W +: SYM_W])),
            .phase     (phase),
            .xval      (xval),
            .level     (pin_in[k]),
            .drive_en  (pin_drive_en[k]),
            .drive_val (pin_drive_val[k]),
            .pull_en   (pin_pull_en[k]),
            .pull_val  (pin_pull_val[k]),
            .err       (pin_err[k]),
            .is_x      (pin_x[k])
         );
      end
   endgenerate

   pvc_seq #(
      .PINS(PINS), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .run_len    (run_len),
      .has_x      (|pin_x),
      .pin_err    (pin_err),
      .phase      (phase),
      .xval       (xval),
      .idx        (idx),
      .busy       (busy),
      .done       (done),
      .fail       (fail),
      .all_pass   (all_pass),
      .fail_index (fail_index),
      .fail_mask  (fail_mask)
   );

endmodule

// File: rtl/pin_vector_checker_chk.sv
module pin_vector_checker_chk #(
   parameter int PINS = 20
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            busy,
   input logic            done,
   input logic            fail,
   input logic            all_pass,
   input logic [PINS-1:0] fail_mask,
   input logic [PINS-1:0] pin_drive_en,
   input logic [PINS-1:0] pin_pull_en,
   input logic [PINS-1:0] pin_pull_val
);

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (pin_drive_en == '0) && (pin_pull_en == '0)); // R10

   AST_DRIVE_PULL_APART: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_drive_en & pin_pull_en) == '0); // R7

   AST_PULL_DIR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pull_val & ~pin_pull_en) == '0); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

   AST_DONE_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R10

   AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(fail && all_pass)); // R9

   AST_FAIL_NAMES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (fail_mask != '0)); // R8

   AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(fail) && $stable(all_pass) && $stable(fail_mask)); // R8

endmodule

bind pin_vector_checker pin_vector_checker_chk #(.PINS(PINS)) u_chk (.*);

// File: tb/pin_vector_checker_tb.sv
`timescale 1ns/1ps
module pin_vector_checker_tb;

   // Symbol codes as stated in R1
   localparam logic [2:0] C_SKIP = 3'd0, C_LO = 3'd1, C_HI = 3'd2, C_X = 3'd3,
                          C_EH = 3'd4, C_EL = 3'd5, C_EZ = 3'd6, C_CK = 3'd7;

   typedef struct packed {
      logic        busy, done, fail, allp;
      logic [7:0]  idx;
      logic [19:0] mask, den, dval, pen, pval;
   } rec_t;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        wr_en = 1'b0, start = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [59:0] wr_data = '0;
   logic [8:0]  run_len = '0;
   logic [19:0] pin_in, pin_drive_en, pin_drive_val, pin_pull_en, pin_pull_val;
   logic        busy, done, fail, all_pass;
   logic [7:0]  fail_index;
   logic [19:0] fail_mask;
   logic        dev_reg;

   int   checks = 0, errors = 0;
   rec_t q[$];
   rec_t idle_rec = '0;
   logic [59:0] bvec [256];
   logic m_reg = 1'b0;

   always #4 clk = ~clk;

   pin_vector_checker u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .start(start), .run_len(run_len), .pin_in(pin_in),
      .pin_drive_en(pin_drive_en), .pin_drive_val(pin_drive_val),
      .pin_pull_en(pin_pull_en), .pin_pull_val(pin_pull_val),
      .busy(busy), .done(done), .fail(fail), .all_pass(all_pass),
      .fail_index(fail_index), .fail_mask(fail_mask)
   );

   // Device under test model: 12=0&1, 13=2^3, 14=flop of 4 clocked by 9,
   // 15 driven with 5 when 6 is high, otherwise floating.
   function automatic logic [19:0] dev_levels(input logic [19:0] den, dval, pen, pval,
                                              input logic r);
      logic [19:0] ext, dd, dv;
      ext = (den & dval) | (~den & pen & pval);
      dd = '0; dv = '0;
      dd[12] = 1'b1; dv[12] = ext[0] & ext[1];
      dd[13] = 1'b1; dv[13] = ext[2] ^ ext[3];
      dd[14] = 1'b1; dv[14] = r;
      dd[15] = ext[6]; dv[15] = ext[5];
      return (den & dval) | (~den & dd & dv) | (~den & ~dd & pen & pval);
   endfunction

   always_comb pin_in = dev_levels(pin_drive_en, pin_drive_val, pin_pull_en, pin_pull_val, dev_reg);

   always @(posedge pin_in[9] or negedge rst_n)
      if (!rst_n) dev_reg <= 1'b0; else dev_reg <= pin_in[4];

   function automatic logic [59:0] put(input logic [59:0] v, input int k, input logic [2:0] s);
      logic [59:0] r;
      r = v;
      r[3*k +: 3] = s;
      return r;
   endfunction

   // Expected per-cycle record stream for a run of n vectors
   task automatic gen_run(input int n);
      rec_t r;
      logic [19:0] dm, cm, zm, hm, lm, xm, lv, rh, rl, err;
      logic [2:0]  s;
      if (n == 0) begin
         r = '0; r.done = 1'b1; r.allp = 1'b1; q.push_back(r);
         r.done = 1'b0; idle_rec = r;
         return;
      end
      for (int i = 0; i < n; i++) begin
         r = '0; r.busy = 1'b1; q.push_back(r);     // fetch cycle (R11)
         dm = '0; cm = '0; zm = '0; hm = '0; lm = '0; xm = '0;
         for (int k = 0; k < 20; k++) begin
            s = bvec[i][3*k +: 3];
            dm[k] = (s == C_LO) || (s == C_HI) || (s == C_X) || (s == C_CK);
            cm[k] = (s == C_CK);
            zm[k] = (s == C_EZ);
            hm[k] = (s == C_EH);
            lm[k] = (s == C_EL);
            xm[k] = (s == C_X);
         end
         for (int p = 0; p < ((xm != '0) ? 2 : 1); p++) begin
            lv = '0;
            for (int k = 0; k < 20; k++)
               lv[k] = (bvec[i][3*k +: 3] == C_HI) || (xm[k] && (p == 1));
            for (int ph = 0; ph < 6; ph++) begin
               r = '0; r.busy = 1'b1;
               r.den  = dm;
               r.dval = lv | ((ph == 1) ? cm : 20'h0);
               r.pen  = (ph == 3 || ph == 4) ? zm : 20'h0;
               r.pval = (ph == 3) ? zm : 20'h0;
               q.push_back(r);
            end
            if (cm[9]) begin
               rh = dev_levels(dm, lv, '0, '0, m_reg);
               m_reg = rh[4];
            end
            rh  = dev_levels(dm, lv, zm, zm, m_reg);
            rl  = dev_levels(dm, lv, zm, '0, m_reg);
            err = (hm & ~rh) | (lm & rh) | (zm & ~rh) | (zm & rl);
            if (err != '0) begin
               r = '0; r.done = 1'b1; r.fail = 1'b1; r.idx = i[7:0]; r.mask = err;
               q.push_back(r);
               r.done = 1'b0; idle_rec = r;
               return;
            end
         end
      end
      r = '0; r.done = 1'b1; r.allp = 1'b1; q.push_back(r);
      r.done = 1'b0; idle_rec = r;
   endtask

   task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
      end
   endtask

   task automatic check_cycle();
      rec_t e;
      e = (q.size() > 0) ? q.pop_front() : idle_rec;
      cmp("R11 busy", 32'(busy), 32'(e.busy));
      cmp("R10 done", 32'(done), 32'(e.done));
      cmp("R8 fail", 32'(fail), 32'(e.fail));
      cmp("R9 all_pass", 32'(all_pass), 32'(e.allp));
      cmp("R8 fail_index", 32'(fail_index), 32'(e.idx));
      cmp("R6/R8 fail_mask", 32'(fail_mask), 32'(e.mask));
      cmp("R1/R3/R4 drive_en", 32'(pin_drive_en), 32'(e.den));
      cmp("R3/R4/R5 drive_val", 32'(pin_drive_val), 32'(e.dval));
      cmp("R7 pull_en", 32'(pin_pull_en), 32'(e.pen));
      cmp("R7 pull_val", 32'(pin_pull_val), 32'(e.pval));
   endtask

   task automatic tick();
      @(negedge clk);
      check_cycle();
   endtask

   task automatic write_vec(input int a, input logic [59:0] v, input bit lands);
      wr_en = 1'b1; wr_addr = a[7:0]; wr_data = v;
      if (lands) bvec[a] = v;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic run(input int n);
      run_len = n[8:0];
      start = 1'b1;
      gen_run(n);
      tick();
      start = 1'b0;
      while (q.size() != 0) tick();
      tick();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R11: run never ended, actual busy %0d expected idle", busy);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [59:0] v;
      repeat (3) @(negedge clk);
      // R2: reset state
      cmp("R2 busy", 32'(busy), 0);
      cmp("R2 done", 32'(done), 0);
      cmp("R2 fail/all_pass", 32'({fail, all_pass}), 0);
      cmp("R2 drive_en", 32'(pin_drive_en), 0);
      cmp("R2 pull_en", 32'(pin_pull_en), 0);
      rst_n = 1'b1;
      tick();

      // v0: AND and XOR outputs high (R3 R6)
      v = '0; v = put(v,0,C_HI); v = put(v,1,C_HI); v = put(v,12,C_EH);
      v = put(v,2,C_LO); v = put(v,3,C_HI); v = put(v,13,C_EH);
      write_vec(0, v, 1);
      // v1: don't-care pins, two passes, both pass (R4)
      v = '0; v = put(v,0,C_X); v = put(v,1,C_LO); v = put(v,12,C_EL);
      v = put(v,2,C_X); v = put(v,3,C_X); v = put(v,13,C_EL);
      write_vec(1, v, 1);
      // v2: clock in a 1 (R5)
      v = '0; v = put(v,4,C_HI); v = put(v,9,C_CK); v = put(v,14,C_EH);
      write_vec(2, v, 1);
      // v3: floating pins follow the pull (R7)
      v = '0; v = put(v,6,C_LO); v = put(v,15,C_EZ); v = put(v,16,C_EZ);
      write_vec(3, v, 1);
      // v4: clock in a 0 (R5)
      v = '0; v = put(v,4,C_LO); v = put(v,9,C_CK); v = put(v,14,C_EL);
      write_vec(4, v, 1);

      // Run A: all pass (R9); mid-run write and start are ignored (R1 R10)
      run_len = 9'd5; start = 1'b1; gen_run(5); tick(); start = 1'b0;
      repeat (4) tick();
      start = 1'b1; tick(); start = 1'b0;
      write_vec(0, '1, 0);
      while (q.size() != 0) tick();
      tick();

      // Run E: vector 0 still the original one (R1)
      run(1);

      // Run B: driven pin expected floating fails the low pull (R7 R8)
      v = '0; v = put(v,5,C_HI); v = put(v,6,C_HI); v = put(v,15,C_EZ);
      write_vec(5, v, 1);
      run(6);

      // Run C: failure only in the second don't-care pass (R4 R8)
      v = '0; v = put(v,0,C_X); v = put(v,1,C_HI); v = put(v,12,C_EL);
      write_vec(1, v, 1);
      run(3);

      // Run G: several failing pins in one vector, skipped pins ignored (R3 R6 R8)
      v = '0; v = put(v,0,C_HI); v = put(v,1,C_HI); v = put(v,12,C_EH);
      v = put(v,2,C_HI); v = put(v,3,C_HI); v = put(v,13,C_EH); v = put(v,17,C_EH);
      write_vec(0, v, 1);
      run(1);

      // Run D: zero length ends at once with a pass (R9)
      run(0);
      repeat (3) tick();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule